// File: doc/BRIEF.md
# Selected Reference Fast Monitor

This block watches the reference clock that a DPLL is tracking and decides how the DPLL reacts when that reference stops or drifts. A synchronized one-cycle strobe marks each reference edge. A gap counter, clocked by the system clock, runs between strobes. If the gap grows past a timeout derived from the configured nominal period, the block declares a no-activity event. The same counter measures each edge-to-edge interval, and the block flags any interval that lies outside roughly one percent of nominal.

A no-activity event at once forces mini-holdover, so the loop filter stops following the reference. The event also latches a failure status bit. That bit drives an interrupt request and a failure pin, each through its own enable. A mode bit, sampled at the event, picks one of two recovery styles. In the first, lock is kept and tracking resumes with nearest-edge (±180°) locking. In the second, loss of lock is declared and the loop relocks with phase/frequency (±360°) locking until the loop reports phase lock again. While the slower activity monitor holds its alarm, mini-holdover stays asserted. No-activity and out-of-range events also leave the block as fill strobes for a leaky-bucket activity monitor.

Top module: `ref_fast_monitor`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, all outputs are 0.
- R2: With `highRate` = 0 and N = `nomPeriod`, let T = 2N + floor(N/2). If the last reference strobe is sampled at clock edge E and no strobe follows, `miniHoldover` is still 0 after edge E+T-1 and is 1 after edge E+T.
- R3: With `highRate` = 1, the same rule applies with T = 4N + floor(N/2). The shorter timeout for `highRate` = 0 must not fire.
- R4: Each sampled strobe restarts the gap count, so strobes spaced closer than T never raise `miniHoldover`.
- R5: A no-activity event sets `srFail`, and `srFail` stays 1 after the reference returns. A `statusClr` pulse clears it on the next edge. If a no-activity event occurs in the same cycle as the clear, the event wins. An out-of-range interval does not set `srFail`.
- R6: `irq` equals (`srFail` AND `failIrqEn`) OR (`lossOfLock` AND `lolIrqEn`), and it follows changes of the enable inputs in the same cycle.
- R7: `failPin` equals `srFail` AND `pinEn`.
- R8: If `lolMode` = 0 at the event, `lossOfLock` and `lockModePf` stay 0 (nearest-edge relock). `miniHoldover` returns to 0 on the edge after the first strobe sampled with `actAlarm` = 0.
- R9: If `lolMode` = 1 at the event, `lossOfLock` and `lockModePf` (1 = phase/frequency lock) rise together with `miniHoldover`. They stay 1 after the reference returns. Both clear on the edge after `dpllLocked` is sampled as 1 while `miniHoldover` is 0. `dpllLocked` has no effect during mini-holdover.
- R10: While `actAlarm` = 1, reference strobes do not end mini-holdover. The first strobe after the alarm drops does end it.
- R11: The interval P is the number of clock edges between two consecutive sampled strobes. The edge after the second strobe, `rangeFault` pulses for one cycle if P < N − tol or P > N + tol, where tol = floor(N/128) + floor(N/512). The first strobe after reset, and the first strobe after a no-activity event, are not checked.
- R12: `fillEvent` pulses for one cycle on each no-activity event (together with the rise of `miniHoldover`) and on each `rangeFault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refEdge | input | 1 | One-cycle strobe per reference edge, already synchronized |
| nomPeriod | input | CNT_W | Nominal reference period in system clocks |
| highRate | input | 1 | 1 selects the four-cycle missing limit |
| lolMode | input | 1 | 1: no-activity declares loss of lock |
| actAlarm | input | 1 | Alarm from the slow activity monitor |
| dpllLocked | input | 1 | Phase lock reported by the DPLL loop |
| failIrqEn | input | 1 | Interrupt enable for the failure status |
| lolIrqEn | input | 1 | Interrupt enable for loss of lock |
| pinEn | input | 1 | Failure pin follows the status bit when 1 |
| statusClr | input | 1 | One-to-clear pulse for the failure status |
| miniHoldover | output | 1 | Isolate the DPLL from the reference |
| srFail | output | 1 | Latched reference failure status |
| irq | output | 1 | Interrupt request |
| failPin | output | 1 | Failure output pin |
| lossOfLock | output | 1 | Loss of lock declared |
| lockModePf | output | 1 | 1: phase/frequency lock, 0: nearest-edge lock |
| rangeFault | output | 1 | Pulse: interval outside tolerance |
| fillEvent | output | 1 | Pulse: fill event for the leaky bucket |

## Verification
A wrong gap count or a wrong threshold moves the rise of `miniHoldover` by one or more clock edges. The bench samples the edge before and the edge at the expected timeout, so the error shows within a single cycle. A wrong history flag or a wrong tolerance shows up as a `rangeFault` pulse that appears or vanishes on the edge after the strobe. Holdover and lock state that is lost or stuck shows up within a cycle or two of the returning strobe, the `dpllLocked` sample, the `statusClr` pulse or the change of an enable.

// File: rtl/ref_mon_pkg.sv
package ref_mon_pkg;

  // events from the datapath to the control
  typedef struct packed {
    logic noActivity;
    logic edgeSeen;
  } mon_evt_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic clearHistory;
  } mon_cmd_t;

  typedef enum logic [0:0] {
    TRACKING = 1'b0,
    HOLDOVER = 1'b1
  } mon_state_t;

endpackage

// File: rtl/ref_mon_datapath.sv
module ref_mon_datapath
  import ref_mon_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int LIMIT_STD   = 2,
  parameter int LIMIT_HIGH  = 4,
  parameter int TOL_SHIFT_A = 7,
  parameter int TOL_SHIFT_B = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refEdge,
  input  logic [CNT_W-1:0] nomPeriod,
  input  logic             highRate,
  input  mon_cmd_t         cmd,
  output mon_evt_t         evt,
  output logic             rangeFault,
  output logic             fillEvent
);

  localparam int CW = CNT_W + $clog2(LIMIT_HIGH + 1) + 1;

  logic [CW-1:0] nomExt;
  logic [CW-1:0] halfNom;
  logic [CW-1:0] thr;
  logic [CW-1:0] gapCnt;
  logic [CW-1:0] period;
  logic [CW-1:0] tol;
  logic [CW-1:0] loBound;
  logic [CW-1:0] hiBound;
  logic          havePrev;
  logic          noAct;
  logic          rangeBad;

  assign nomExt  = CW'(nomPeriod);
  assign halfNom = nomExt >> 1;

  // timeout = (limit + 0.5) nominal periods
  assign thr = (highRate ? nomExt * CW'(LIMIT_HIGH) : nomExt * CW'(LIMIT_STD)) + halfNom;

  // frequency tolerance picked by parameters
  generate
    if (TOL_SHIFT_B > 0) begin : g_tolTwoTerm
      assign tol = (nomExt >> TOL_SHIFT_A) + (nomExt >> TOL_SHIFT_B);
    end else begin : g_tolOneTerm
      assign tol = nomExt >> TOL_SHIFT_A;
    end
  endgenerate

  assign loBound = nomExt - tol;
  assign hiBound = nomExt + tol;
  assign period  = gapCnt + CW'(1);

  // gap counter: restarts on every strobe, parks at the threshold
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (refEdge) begin
      gapCnt <= '0;
    end else if (gapCnt < thr) begin
      gapCnt <= gapCnt + CW'(1);
    end
  end

  assign noAct = !refEdge && (thr != '0) && (gapCnt == thr - CW'(1));

  // a previous strobe is needed before an interval can be judged
  always_ff @(posedge clk) begin
    if (!rstN) begin
      havePrev <= 1'b0;
    end else if (cmd.clearHistory) begin
      havePrev <= 1'b0;
    end else if (refEdge) begin
      havePrev <= 1'b1;
    end
  end

  assign rangeBad = refEdge && havePrev && ((period < loBound) || (period > hiBound));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rangeFault <= 1'b0;
      fillEvent  <= 1'b0;
    end else begin
      rangeFault <= rangeBad;
      fillEvent  <= rangeBad | noAct;
    end
  end

  assign evt.noActivity = noAct;
  assign evt.edgeSeen   = refEdge;

endmodule

// File: rtl/ref_mon_control.sv
module ref_mon_control
  import ref_mon_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  mon_evt_t evt,
  input  logic     lolMode,
  input  logic     actAlarm,
  input  logic     dpllLocked,
  input  logic     failIrqEn,
  input  logic     lolIrqEn,
  input  logic     pinEn,
  input  logic     statusClr,
  output mon_cmd_t cmd,
  output logic     miniHoldover,
  output logic     srFail,
  output logic     irq,
  output logic     failPin,
  output logic     lossOfLock,
  output logic     lockModePf
);

  mon_state_t state;
  mon_state_t stateNext;
  logic       enterHold;
  logic       relockDone;
  logic       lolQ;
  logic       pfQ;
  logic       failQ;

  always_comb begin
    stateNext = state;
    case (state)
      TRACKING: if (evt.noActivity) stateNext = HOLDOVER;
      HOLDOVER: if (evt.edgeSeen && !actAlarm) stateNext = TRACKING;
      default:  stateNext = TRACKING;
    endcase
  end

  assign enterHold  = (state == TRACKING) && evt.noActivity;
  assign relockDone = (state == TRACKING) && !evt.noActivity && dpllLocked && lolQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= TRACKING;
      lolQ  <= 1'b0;
      pfQ   <= 1'b0;
      failQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (enterHold) begin
        lolQ <= lolQ | lolMode;
        pfQ  <= pfQ | lolMode;
      end else if (relockDone) begin
        lolQ <= 1'b0;
        pfQ  <= 1'b0;
      end
      if (evt.noActivity) begin
        failQ <= 1'b1;
      end else if (statusClr) begin
        failQ <= 1'b0;
      end
    end
  end

  assign cmd.clearHistory = evt.noActivity;

  assign miniHoldover = (state == HOLDOVER);
  assign srFail       = failQ;
  assign lossOfLock   = lolQ;
  assign lockModePf   = pfQ;
  assign irq          = (failQ & failIrqEn) | (lolQ & lolIrqEn);
  assign failPin      = failQ & pinEn;

endmodule

// File: rtl/ref_fast_monitor.sv
module ref_fast_monitor
  import ref_mon_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int LIMIT_STD   = 2,
  parameter int LIMIT_HIGH  = 4,
  parameter int TOL_SHIFT_A = 7,
  parameter int TOL_SHIFT_B = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refEdge,
  input  logic [CNT_W-1:0] nomPeriod,
  input  logic             highRate,
  input  logic             lolMode,
  input  logic             actAlarm,
  input  logic             dpllLocked,
  input  logic             failIrqEn,
  input  logic             lolIrqEn,
  input  logic             pinEn,
  input  logic             statusClr,
  output logic             miniHoldover,
  output logic             srFail,
  output logic             irq,
  output logic             failPin,
  output logic             lossOfLock,
  output logic             lockModePf,
  output logic             rangeFault,
  output logic             fillEvent
);

  mon_evt_t evt;
  mon_cmd_t cmd;

  ref_mon_datapath #(
    .CNT_W      (CNT_W),
    .LIMIT_STD  (LIMIT_STD),
    .LIMIT_HIGH (LIMIT_HIGH),
    .TOL_SHIFT_A(TOL_SHIFT_A),
    .TOL_SHIFT_B(TOL_SHIFT_B)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .refEdge   (refEdge),
    .nomPeriod (nomPeriod),
    .highRate  (highRate),
    .cmd       (cmd),
    .evt       (evt),
    .rangeFault(rangeFault),
    .fillEvent (fillEvent)
  );

  ref_mon_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .evt         (evt),
    .lolMode     (lolMode),
    .actAlarm    (actAlarm),
    .dpllLocked  (dpllLocked),
    .failIrqEn   (failIrqEn),
    .lolIrqEn    (lolIrqEn),
    .pinEn       (pinEn),
    .statusClr   (statusClr),
    .cmd         (cmd),
    .miniHoldover(miniHoldover),
    .srFail      (srFail),
    .irq         (irq),
    .failPin     (failPin),
    .lossOfLock  (lossOfLock),
    .lockModePf  (lockModePf)
  );

endmodule

// File: rtl/ref_mon_checker.sv
module ref_mon_checker (
  input logic clk,
  input logic rstN,
  input logic statusClr,
  input logic actAlarm,
  input logic miniHoldover,
  input logic srFail,
  input logic lossOfLock,
  input logic lockModePf,
  input logic rangeFault,
  input logic fillEvent
);

  // R2 / R12: holdover entry comes with a fill strobe and the status bit
  assert_entry_marks_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(miniHoldover) |-> (fillEvent && srFail));

  // R5: status holds unless cleared
  assert_status_latched_R5: assert property (@(posedge clk) disable iff (!rstN)
    (srFail && !statusClr) |=> srFail);

  // R9: loss of lock is only declared on holdover entry
  assert_lol_on_entry_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lossOfLock) |-> miniHoldover);

  // R9: loss of lock always selects phase/frequency locking
  assert_lol_pf_R9: assert property (@(posedge clk) disable iff (!rstN)
    lossOfLock |-> lockModePf);

  // R10: activity alarm keeps holdover asserted
  assert_alarm_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (miniHoldover && actAlarm) |=> miniHoldover);

  // R12: every range fault is also a fill event
  assert_range_fill_R12: assert property (@(posedge clk) disable iff (!rstN)
    rangeFault |-> fillEvent);

endmodule

bind ref_fast_monitor ref_mon_checker u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .statusClr   (statusClr),
  .actAlarm    (actAlarm),
  .miniHoldover(miniHoldover),
  .srFail      (srFail),
  .lossOfLock  (lossOfLock),
  .lockModePf  (lockModePf),
  .rangeFault  (rangeFault),
  .fillEvent   (fillEvent)
);

// File: tb/ref_fast_monitor_bench.sv
module ref_fast_monitor_bench;

  localparam int NOM = 200;
  localparam int TLO = 2 * NOM + NOM / 2;
  localparam int THI = 4 * NOM + NOM / 2;

  localparam int S_HOLD  = 0;
  localparam int S_FAIL  = 1;
  localparam int S_IRQ   = 2;
  localparam int S_PIN   = 3;
  localparam int S_LOL   = 4;
  localparam int S_PF    = 5;
  localparam int S_RANGE = 6;
  localparam int S_FILL  = 7;

  logic        clk = 1'b0;
  logic        rstN;
  logic        refEdge;
  logic [11:0] nomPeriod;
  logic        highRate, lolMode, actAlarm, dpllLocked;
  logic        failIrqEn, lolIrqEn, pinEn, statusClr;
  logic        miniHoldover, srFail, irq, failPin, lossOfLock, lockModePf, rangeFault, fillEvent;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int    cyc;
    int    sig;
    logic  val;
    string req;
  } exp_t;
  exp_t sbq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ref_fast_monitor u_ref_fast_monitor (
    .clk(clk), .rstN(rstN), .refEdge(refEdge), .nomPeriod(nomPeriod),
    .highRate(highRate), .lolMode(lolMode), .actAlarm(actAlarm), .dpllLocked(dpllLocked),
    .failIrqEn(failIrqEn), .lolIrqEn(lolIrqEn), .pinEn(pinEn), .statusClr(statusClr),
    .miniHoldover(miniHoldover), .srFail(srFail), .irq(irq), .failPin(failPin),
    .lossOfLock(lossOfLock), .lockModePf(lockModePf), .rangeFault(rangeFault),
    .fillEvent(fillEvent)
  );

  function automatic logic pick(int s);
    case (s)
      S_HOLD:  return miniHoldover;
      S_FAIL:  return srFail;
      S_IRQ:   return irq;
      S_PIN:   return failPin;
      S_LOL:   return lossOfLock;
      S_PF:    return lockModePf;
      S_RANGE: return rangeFault;
      default: return fillEvent;
    endcase
  endfunction

  function automatic string sigName(int s);
    case (s)
      S_HOLD:  return "miniHoldover";
      S_FAIL:  return "srFail";
      S_IRQ:   return "irq";
      S_PIN:   return "failPin";
      S_LOL:   return "lossOfLock";
      S_PF:    return "lockModePf";
      S_RANGE: return "rangeFault";
      default: return "fillEvent";
    endcase
  endfunction

  task automatic pushExp(int at, int s, logic v, string req);
    exp_t e;
    e.cyc = at; e.sig = s; e.val = v; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic idleTo(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic sendEdge(output int at);
    at = cyc;
    refEdge = 1'b1;
    @(negedge clk);
    refEdge = 1'b0;
  endtask

  // monitor: compare expectations in the cycle they are due
  initial begin : monitor
    exp_t e;
    logic got;
    forever begin
      @(negedge clk);
      #5;
      while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
        e = sbq.pop_front();
        got = pick(e.sig);
        checks++;
        if (e.cyc != cyc) begin
          errors++;
          $display("FAIL %s %s stale expectation for cycle %0d at cycle %0d: got %0b expected %0b",
                   e.req, sigName(e.sig), e.cyc, cyc, got, e.val);
        end else if (got !== e.val) begin
          errors++;
          $display("FAIL %s %s at cycle %0d: got %0b expected %0b",
                   e.req, sigName(e.sig), cyc, got, e.val);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    int c, c2, d;
    refEdge = 0; nomPeriod = 12'(NOM); highRate = 0; lolMode = 0; actAlarm = 0;
    dpllLocked = 0; failIrqEn = 1; lolIrqEn = 1; pinEn = 1; statusClr = 0; rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    for (int s = 0; s < 8; s++) pushExp(cyc + 1, s, 1'b0, "R1");
    @(negedge clk);

    // steady reference, nominal and tolerated intervals
    sendEdge(c);
    for (int k = 0; k < 3; k++) begin
      idleTo(c + NOM); sendEdge(c);
      pushExp(c + 1, S_RANGE, 1'b0, "R11");
      pushExp(c + 1, S_HOLD, 1'b0, "R4");
    end
    idleTo(c + NOM + 1); sendEdge(c);
    pushExp(c + 1, S_RANGE, 1'b0, "R11");
    idleTo(c + NOM + 3); sendEdge(c);
    pushExp(c + 1, S_RANGE, 1'b1, "R11");
    pushExp(c + 1, S_FILL, 1'b1, "R12");
    pushExp(c + 2, S_RANGE, 1'b0, "R11");
    idleTo(c + NOM - 3); sendEdge(c);
    pushExp(c + 1, S_RANGE, 1'b1, "R11");
    pushExp(c + 1, S_FAIL, 1'b0, "R5");

    // low-rate timeout, nearest-edge recovery
    pushExp(c + TLO, S_HOLD, 1'b0, "R2");
    pushExp(c + TLO + 1, S_HOLD, 1'b1, "R2");
    pushExp(c + TLO + 1, S_FILL, 1'b1, "R12");
    pushExp(c + TLO + 1, S_FAIL, 1'b1, "R5");
    pushExp(c + TLO + 1, S_IRQ, 1'b1, "R6");
    pushExp(c + TLO + 1, S_PIN, 1'b1, "R7");
    pushExp(c + TLO + 1, S_LOL, 1'b0, "R8");
    pushExp(c + TLO + 1, S_PF, 1'b0, "R8");
    pushExp(c + TLO + 2, S_FILL, 1'b0, "R12");
    idleTo(c + TLO + 100); sendEdge(c2);
    pushExp(c2 + 1, S_HOLD, 1'b0, "R8");
    pushExp(c2 + 1, S_PF, 1'b0, "R8");
    pushExp(c2 + 1, S_FAIL, 1'b1, "R5");
    pushExp(c2 + 1, S_RANGE, 1'b0, "R11");
    idleTo(c2 + 10); d = cyc;
    pinEn = 0; failIrqEn = 0;
    pushExp(d, S_PIN, 1'b0, "R7");
    pushExp(d, S_IRQ, 1'b0, "R6");
    @(negedge clk);
    pinEn = 1; failIrqEn = 1;
    pushExp(d + 1, S_PIN, 1'b1, "R7");
    pushExp(d + 1, S_IRQ, 1'b1, "R6");
    @(negedge clk);
    statusClr = 1;
    pushExp(d + 2, S_FAIL, 1'b1, "R5");
    pushExp(d + 3, S_FAIL, 1'b0, "R5");
    pushExp(d + 3, S_IRQ, 1'b0, "R6");
    pushExp(d + 3, S_PIN, 1'b0, "R7");
    @(negedge clk);
    statusClr = 0;
    idleTo(c2 + NOM); sendEdge(c);

    // high-rate timeout with a clear in the event cycle, then alarm hold
    highRate = 1;
    pushExp(c + TLO + 1, S_HOLD, 1'b0, "R3");
    pushExp(c + THI - 1, S_FAIL, 1'b0, "R5");
    pushExp(c + THI, S_HOLD, 1'b0, "R3");
    idleTo(c + THI);
    statusClr = 1;
    pushExp(c + THI + 1, S_HOLD, 1'b1, "R3");
    pushExp(c + THI + 1, S_FAIL, 1'b1, "R5");
    @(negedge clk);
    statusClr = 0;
    actAlarm = 1;
    idleTo(c + THI + 100); sendEdge(c2);
    pushExp(c2 + 1, S_HOLD, 1'b1, "R10");
    idleTo(c2 + NOM); sendEdge(c2);
    pushExp(c2 + 1, S_HOLD, 1'b1, "R10");
    actAlarm = 0;
    idleTo(c2 + NOM); sendEdge(c);
    pushExp(c + 1, S_HOLD, 1'b0, "R10");
    highRate = 0;

    // loss-of-lock mode with phase/frequency relock
    idleTo(c + 20);
    statusClr = 1;
    @(negedge clk);
    statusClr = 0;
    idleTo(c + NOM); sendEdge(c);
    lolMode = 1; failIrqEn = 0;
    pushExp(c + TLO, S_LOL, 1'b0, "R9");
    pushExp(c + TLO, S_IRQ, 1'b0, "R6");
    pushExp(c + TLO + 1, S_HOLD, 1'b1, "R9");
    pushExp(c + TLO + 1, S_LOL, 1'b1, "R9");
    pushExp(c + TLO + 1, S_PF, 1'b1, "R9");
    pushExp(c + TLO + 1, S_IRQ, 1'b1, "R6");
    idleTo(c + TLO + 20);
    dpllLocked = 1;
    pushExp(c + TLO + 30, S_LOL, 1'b1, "R9");
    idleTo(c + TLO + 40);
    dpllLocked = 0;
    idleTo(c + TLO + 100); sendEdge(c2);
    pushExp(c2 + 1, S_HOLD, 1'b0, "R9");
    pushExp(c2 + 1, S_LOL, 1'b1, "R9");
    pushExp(c2 + 1, S_PF, 1'b1, "R9");
    idleTo(c2 + 5); d = cyc;
    dpllLocked = 1;
    pushExp(d, S_LOL, 1'b1, "R9");
    pushExp(d + 1, S_LOL, 1'b0, "R9");
    pushExp(d + 1, S_PF, 1'b0, "R9");
    pushExp(d + 1, S_IRQ, 1'b0, "R6");
    @(negedge clk);
    dpllLocked = 0;
    idleTo(c2 + NOM); sendEdge(c);
    pushExp(c + 1, S_HOLD, 1'b0, "R4");
    idleTo(c + 10);

    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule